// File: doc/BRIEF.md
# Chip-Enable-Strobed Bytewide Memory Controller

This block sits on the host side of a bytewide nonvolatile RAM with 32K locations. That memory captures its address only when chip-enable falls. A client issues a read or a write through a simple request port: a valid strobe, a direction bit, a 15-bit address and 8 bits of write data. The controller accepts the request only when it shows ready. It then runs one complete memory cycle on the pins: chip-enable, output-enable, write-enable, the address bus and the bidirectional data bus. When the cycle ends it returns a one-cycle done pulse, together with the read data for a read.

Each access gets its own chip-enable falling edge. Before that edge there is always a setup cycle with chip-enable high and the address already stable. After the access, chip-enable stays high long enough to precharge the memory. All timing is counted in clock cycles. The counts come from the clock period, the access time and the cycle time, which are parameters.

The phase lengths are derived as follows. ACT = ceil(ACCESS_NS / CLK_PERIOD_NS) + 1, which is 8 at the defaults of 10 ns, 70 ns and 140 ns. PRE = max(1, ceil((CYCLE_NS - ACT*CLK_PERIOD_NS) / CLK_PERIOD_NS)), which is 6 at the defaults.

Top module: `cestrobe_mem_ctl`

## Requirements
- R1: While reset is high, and on the first cycle after it, chip-enable, output-enable and write-enable are all high (inactive), ready is high and done is low. No chip-enable falling edge occurs during reset, even with a request pending.
- R2: A request is taken only on a clock edge where req_valid and req_ready are both high. Ready drops on the next cycle and stays low until the cycle finishes. A request offered while ready is low is ignored: it starts no memory access and changes no location.
- R3: Every accepted request produces exactly one chip-enable falling edge. The address is on the pins at least one cycle before that edge and does not change while chip-enable is low.
- R4: Chip-enable stays low for exactly ACT clock cycles per access (8 at the defaults, i.e. 80 ns).
- R5: Between two accesses chip-enable stays high for at least CYCLE_NS - ACCESS_NS (70 ns). Two successive chip-enable falling edges are at least CYCLE_NS (140 ns) apart, even when requests are issued back to back.
- R6: For a write, write-enable is low only while chip-enable is low and output-enable stays high. The controller drives the write data on the bus from the setup cycle until chip-enable rises. It never drives the bus while output-enable is low. The written byte is stored at the request address.
- R7: For a read, output-enable is low only while chip-enable is low and write-enable stays high. The controller releases the bus. The byte on the bus in the last active cycle is returned on rsp_rdata.
- R8: done rises exactly ACT+1 clock edges after the accepting edge and lasts one cycle. Ready returns PRE edges after the edge that raised done. rsp_rdata holds its value until the next read.
- R9: Accesses to address 0x0000 and to address 0x7FFF reach exactly those locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle; request will be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid from done onward |
| mem_ce_n | output | 1 | Memory chip-enable, active low |
| mem_oe_n | output | 1 | Memory output-enable, active low |
| mem_we_n | output | 1 | Memory write-enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The bench attaches an asynchronous memory model. The model latches the address only on a chip-enable falling edge and presents read data only after the access time. A controller that held chip-enable low across accesses, or that sampled too early, would therefore return wrong bytes. The model times every chip-enable edge, so a shortened precharge between back-to-back requests or a wrong active length shows up as a timing miss. A request pulsed while the controller is busy must not add a falling edge or corrupt a location; a design that latched requests blindly would do one or both. The reset test holds a request during reset, to catch a strobe leaking out before reset is released.

// File: rtl/cestrobe_pkg.sv
`timescale 1ns/1ps
package cestrobe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_CAPTURE,
    ST_PRECH
  } seq_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cestrobe_phase_timer.sv
`timescale 1ns/1ps
module cestrobe_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else              count <= count + CW'(1);
  end
endmodule

// File: rtl/cestrobe_seq_fsm.sv
`timescale 1ns/1ps
module cestrobe_seq_fsm
  import cestrobe_pkg::*;
#(
  parameter int ACTIVE_CYC = 8,
  parameter int PRECH_CYC  = 6,
  parameter int CW         = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic rsp_done,
  output logic mem_ce_n,
  output logic mem_oe_n,
  output logic mem_we_n,
  output logic drive_en,
  output logic load_en,
  output logic capture_en
);
  localparam logic [CW-1:0] ACT_LAST = CW'(ACTIVE_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'((PRECH_CYC > 1) ? PRECH_CYC - 2 : 0);

  seq_state_t    state;
  logic          is_wr;
  logic [CW-1:0] cnt;
  logic          act_end;
  logic          pre_end;
  logic          tmr_clear;

  assign act_end    = (state == ST_ACTIVE) && (cnt == ACT_LAST);
  assign pre_end    = (state == ST_PRECH) && (cnt == PRE_LAST);
  assign tmr_clear  = ((state != ST_ACTIVE) && (state != ST_PRECH)) || act_end || pre_end;
  assign load_en    = (state == ST_IDLE) && req_ready && req_valid;
  assign capture_en = act_end && !is_wr;

  cestrobe_phase_timer #(.CW(CW)) timer_i (
    .clk   (clk),
    .rst   (rst),
    .clear (tmr_clear),
    .count (cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      is_wr     <= 1'b0;
      req_ready <= 1'b1;
      rsp_done  <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      drive_en  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          rsp_done <= 1'b0;
          if (load_en) begin
            state     <= ST_SETUP;
            req_ready <= 1'b0;
            is_wr     <= req_write;
            drive_en  <= req_write;
          end
        end
        ST_SETUP: begin
          state    <= ST_ACTIVE;
          mem_ce_n <= 1'b0;
          mem_we_n <= !is_wr;
          mem_oe_n <= is_wr;
        end
        ST_ACTIVE: begin
          if (act_end) begin
            state    <= ST_CAPTURE;
            mem_ce_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_we_n <= 1'b1;
            drive_en <= 1'b0;
            rsp_done <= 1'b1;
          end
        end
        ST_CAPTURE: begin
          rsp_done <= 1'b0;
          if (PRECH_CYC > 1) begin
            state <= ST_PRECH;
          end else begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        ST_PRECH: begin
          if (pre_end) begin
            state     <= ST_IDLE;
            req_ready <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: strobes inactive and controller idle after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_oe_n && mem_we_n && req_ready && !rsp_done));

  // R2: an accepted request takes ready away and leaves chip-enable high for setup
  p_ready_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && mem_ce_n));

  // R4: chip-enable rises only once the active counter has reached its last count
  p_active_len_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_ce_n) |-> ($past(cnt) == ACT_LAST));

  // R6: write-enable low only inside chip-enable low, on a write, with output-enable high
  p_we_window_r6: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && is_wr));

  // R7: output-enable low only inside chip-enable low, on a read, with write-enable high
  p_oe_window_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !is_wr));

  // R8: done is a single-cycle pulse after chip-enable has gone high
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && mem_ce_n));
endmodule

// File: rtl/cestrobe_dq_port.sv
`timescale 1ns/1ps
module cestrobe_dq_port #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              capture_en,
  input  logic              drive_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] rsp_rdata,
  inout  wire  [DATA_W-1:0] mem_dq
);
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      wdata_q   <= '0;
      rsp_rdata <= '0;
    end else begin
      if (load_en) begin
        mem_addr <= req_addr;
        wdata_q  <= req_wdata;
      end
      if (capture_en) rsp_rdata <= mem_dq;
    end
  end

  for (genvar b = 0; b < DATA_W; b++) begin : g_dq_bit
    assign mem_dq[b] = drive_en ? wdata_q[b] : 1'bz;
  end
endmodule

// File: rtl/cestrobe_mem_ctl.sv
`timescale 1ns/1ps
module cestrobe_mem_ctl
  import cestrobe_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ACCESS_NS     = 70,
  parameter int CYCLE_NS      = 140,
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int ACTIVE_CYC = ceil_div(ACCESS_NS, CLK_PERIOD_NS) + 1;
  localparam int PRECH_CYC  = at_least_one(
                   ceil_div(CYCLE_NS - ACTIVE_CYC * CLK_PERIOD_NS, CLK_PERIOD_NS));
  localparam int CW         = $clog2(max2(ACTIVE_CYC, PRECH_CYC) + 1);
  localparam int HW         = $clog2(PRECH_CYC + 1);

  logic drive_en;
  logic load_en;
  logic capture_en;

  cestrobe_seq_fsm #(
    .ACTIVE_CYC (ACTIVE_CYC),
    .PRECH_CYC  (PRECH_CYC),
    .CW         (CW)
  ) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .mem_ce_n   (mem_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .drive_en   (drive_en),
    .load_en    (load_en),
    .capture_en (capture_en)
  );

  cestrobe_dq_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) dq_i (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .capture_en (capture_en),
    .drive_en   (drive_en),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_addr   (mem_addr),
    .rsp_rdata  (rsp_rdata),
    .mem_dq     (mem_dq)
  );

  // Checker counter: consecutive cycles with chip-enable high, saturating
  logic [HW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)                              hi_cnt <= HW'(PRECH_CYC);
    else if (!mem_ce_n)                   hi_cnt <= '0;
    else if (hi_cnt < HW'(PRECH_CYC))     hi_cnt <= hi_cnt + HW'(1);
  end

  // R5: a new falling edge only after the precharge interval has elapsed
  p_prech_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (hi_cnt >= HW'(PRECH_CYC)));

  // R3: address pins frozen while chip-enable is low
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> $stable(mem_addr));

  // R6: bus is never driven by the controller while the memory may drive it
  p_no_drive_oe_r6: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> mem_oe_n);
endmodule

// File: tb/cestrobe_mem_ctl_tb_top.sv
`timescale 1ns/1ps
module cestrobe_mem_ctl_tb_top;
  localparam int  CLK_NS   = 10;
  localparam int  ACC_NS   = 70;
  localparam int  CYC_NS   = 140;
  localparam int  ACT      = (ACC_NS + CLK_NS - 1) / CLK_NS + 1;          // 8
  localparam int  PRE_RAW  = (CYC_NS - ACT * CLK_NS + CLK_NS - 1) / CLK_NS;
  localparam int  PRE      = (PRE_RAW < 1) ? 1 : PRE_RAW;                 // 6

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic        mem_ce_n;
  logic        mem_oe_n;
  logic        mem_we_n;
  logic [14:0] mem_addr;
  wire  [7:0]  mem_dq;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS / 2) clk = ~clk;

  cestrobe_mem_ctl dut_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq    (mem_dq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0]  mdl_mem [int];
  logic [14:0] lat_addr = '0;
  logic [7:0]  mdl_out = '0;
  logic        mdl_valid = 1'b0;
  realtime     t_fall = 0.0;
  realtime     t_rise = -1000.0;
  realtime     t_prev_fall = -1000.0;
  int          falls = 0;

  assign mem_dq = (!mem_ce_n && !mem_oe_n) ? mdl_out : 8'hzz;

  function automatic logic [7:0] mdl_read(input logic [14:0] a);
    return mdl_mem.exists(int'(a)) ? mdl_mem[int'(a)] : 8'h00;
  endfunction

  always @(negedge mem_ce_n) begin
    falls++;
    lat_addr    = mem_addr;
    t_fall      = $realtime;
    mdl_valid   = 1'b0;
    chk((t_fall - t_rise) >= real'(CYC_NS - ACC_NS), "R5 precharge ns",
        longint'(t_fall - t_rise), CYC_NS - ACC_NS);
    chk((t_fall - t_prev_fall) >= real'(CYC_NS), "R5 fall-to-fall ns",
        longint'(t_fall - t_prev_fall), CYC_NS);
    t_prev_fall = t_fall;
  end

  always @(posedge mem_ce_n) begin
    t_rise = $realtime;
    if (!rst && falls > 0)
      chk((t_rise - t_fall) == real'(ACT * CLK_NS), "R4 ce low ns",
          longint'(t_rise - t_fall), ACT * CLK_NS);
  end

  always @(negedge clk) begin
    if (!mem_ce_n) begin
      if (mem_addr != lat_addr)
        chk(1'b0, "R3 address moved while ce low", mem_addr, lat_addr);
      if (!mem_we_n && !mem_oe_n)
        chk(1'b0, "R6/R7 we and oe both low", 0, 1);
      if (!mem_we_n) mdl_mem[int'(lat_addr)] = mem_dq;
      if (($realtime - t_fall) >= real'(ACC_NS)) mdl_valid = 1'b1;
      mdl_out = mdl_valid ? mdl_read(lat_addr) : 8'h5A;
    end else begin
      mdl_valid = 1'b0;
    end
  end

  // ---------------- scenario tasks ----------------
  task automatic do_access(input bit wr, input logic [14:0] a, input logic [7:0] d,
                           output logic [7:0] q, input string tag);
    int n;
    int m;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R2 ready before request"}, req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, {tag, " R2 ready dropped"}, req_ready, 0);
    chk(mem_addr == a, {tag, " R3 address set up"}, mem_addr, a);
    n = 0;
    do begin @(posedge clk); n++; #1; end while (!rsp_done && n < 60);
    chk(n == ACT + 1, {tag, " R8 done latency"}, n, ACT + 1);
    q = rsp_rdata;
    m = 1;
    @(posedge clk); #1;
    chk(rsp_done == 1'b0, {tag, " R8 done one cycle"}, rsp_done, 0);
    while (!req_ready && m < 60) begin @(posedge clk); m++; #1; end
    chk(m == PRE, {tag, " R8 ready return"}, m, PRE);
  endtask

  task automatic t_reset();
    rst = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0005; req_wdata = 8'h77;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(falls == 0, "R1 no ce fall in reset", falls, 0);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    req_valid = 1'b0;
    rst = 1'b0;
    @(posedge clk); #1;
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes high after reset",
        {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_done == 1'b0, "R1 done low after reset", rsp_done, 0);
  endtask

  task automatic t_write_read();
    logic [7:0] q;
    logic [7:0] pat [4] = '{8'hA5, 8'h3C, 8'hFF, 8'h00};
    for (int i = 0; i < 4; i++)
      do_access(1'b1, 15'h0100 + 15'(i * 37), pat[i], q, "R6 write");
    for (int i = 0; i < 4; i++) begin
      do_access(1'b0, 15'h0100 + 15'(i * 37), 8'h00, q, "R7 read");
      chk(q == pat[i], "R7 read data", q, pat[i]);
    end
    do_access(1'b0, 15'h2222, 8'h00, q, "R7 read idle bus");
    chk(q == 8'h00, "R7 unwritten location", q, 8'h00);
  endtask

  task automatic t_boundary();
    logic [7:0] q;
    do_access(1'b1, 15'h0000, 8'h9E, q, "R9 low write");
    do_access(1'b1, 15'h7FFF, 8'h61, q, "R9 high write");
    do_access(1'b0, 15'h0000, 8'h00, q, "R9 low read");
    chk(q == 8'h9E, "R9 address 0x0000", q, 8'h9E);
    do_access(1'b0, 15'h7FFF, 8'h00, q, "R9 high read");
    chk(q == 8'h61, "R9 address 0x7FFF", q, 8'h61);
    chk(rsp_rdata == 8'h61, "R8 rdata held", rsp_rdata, 8'h61);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] q;
    int f0;
    int w;
    do_access(1'b1, 15'h1234, 8'h11, q, "R2 preload");
    f0 = falls;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0100; req_wdata = 8'h00;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h1234; req_wdata = 8'hEE;
    @(negedge clk); req_valid = 1'b0;
    w = 0;
    while (!req_ready && w < 60) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(falls - f0 == 1, "R2 busy request ignored (one access)", falls - f0, 1);
    do_access(1'b0, 15'h1234, 8'h00, q, "R2 check");
    chk(q == 8'h11, "R2 busy write had no effect", q, 8'h11);
  endtask

  task automatic t_back_to_back();
    logic [7:0] q;
    int f0;
    f0 = falls;
    for (int i = 0; i < 3; i++) do_access(1'b0, 15'h7FFF, 8'h00, q, "R5 back-to-back");
    chk(q == 8'h61, "R5 back-to-back data", q, 8'h61);
    chk(falls - f0 == 3, "R3 one fall per access", falls - f0, 3);
  endtask

  initial begin
    t_reset();
    t_write_read();
    t_boundary();
    t_busy_ignore();
    t_back_to_back();
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200_000 * CLK_NS);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule